// File: doc/BRIEF.md
# Dual Down-Counter Timer with APB Register Port

This peripheral holds two independent 32-bit count-down counters. Software programs them through an APB slave port with an 8-bit address and 32-bit data. Each counter has its own load value, control word, sticky zero-event flag and active-high interrupt line. A counter fires its event on the clock edge where it steps from one to zero. It then either restarts from its load value (periodic) or rests at zero (one-shot).

A global mode bit cascades the two words into one 64-bit count-down counter. Counter 1 is the high word and counter 2 the low word. The high word steps only when the low word wraps from zero. Counter 1's control word governs the cascaded counter, and its zero event is reported on interrupt line 1.

A soft-reset input acts like the APB reset and holds every register at zero while it is high. The driver of that input is expected to power up with it asserted.

Top module: `dual_dcount_timer`

## Requirements
- R1: While `presetn` is low or `soft_rst_i` is high, every register reads zero on the next clock, both interrupt lines are low, and APB writes have no effect.
- R2: Writing the load register of counter 1 (0x00) or counter 2 (0x18) sets both that load value and the live count on the same edge. The live count reads back at 0x04 or 0x1C, and writes to those two addresses are ignored.
- R3: A counter whose control bit 0 (run) is set decrements by one on every clock while it is nonzero. A counter with run clear holds its value.
- R4: The zero event occurs on the edge where a running counter goes from 1 to 0, and it sets the raw flag (bit 0 of 0x10 or 0x28). With control bit 2 (periodic) set, the next clock reloads the load value, giving a period of load+1 cycles. With bit 2 clear, the counter stays at zero.
- R5: Each interrupt line equals the raw flag ANDed with control bit 1 (interrupt enable). The masked status at 0x14 or 0x2C reads the same value in bit 0.
- R6: Any write to 0x0C or 0x24 clears that counter's raw flag. A zero event in the same cycle as the clear leaves the flag set.
- R7: With bit 0 of 0x30 set, {count1, count2} decrements as one 64-bit value under counter 1's run, enable and periodic bits. Count1 changes only when count2 was zero or on a load. Reaching zero sets raw flag 1. Counter 2 then produces no zero events.
- R8: The control registers at 0x08 and 0x20 read back bits [2:0] as written. Reads of unmapped addresses and of the clear registers return zero.
- R9: A load write wins over a decrement or reload of the same word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counting clock |
| presetn | input | 1 | Active-low bus reset, sampled on the clock |
| soft_rst_i | input | 1 | Active-high soft reset holding the block cleared |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| irq1_o | output | 1 | Interrupt from counter 1 or the 64-bit counter |
| irq2_o | output | 1 | Interrupt from counter 2 |

## Verification
Counter 1 runs one-shot with its interrupt masked and then unmasked. Comparing the raw and masked flags separates the sticky event from the gated line. Counter 2 runs periodic with a short load while clear writes arrive every three cycles, so over a four-cycle period the clear strikes every phase, including the cycle of the zero event. The cascaded mode is tried with a zero high word, which must fire after the low count, and with a high word of one, which must borrow exactly once. Soft reset is asserted mid-run, load writes land mid-count, and unmapped reads are issued.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int N_CNT    = 2;
    localparam int STRIDE   = 'h18;

    localparam int OFS_LOAD = 'h00;
    localparam int OFS_LIVE = 'h04;
    localparam int OFS_CTRL = 'h08;
    localparam int OFS_CLR  = 'h0C;
    localparam int OFS_RAW  = 'h10;
    localparam int OFS_MSK  = 'h14;
    localparam int ADR_MODE = 'h30;

    typedef struct packed {
        logic periodic;
        logic irq_en;
        logic run;
    } tmr_ctrl_t;

    typedef struct packed {
        logic ld_we;
        logic reload;
        logic dec;
    } word_cmd_t;

    function automatic logic [ADDR_W-1:0] reg_addr(input int idx, input int ofs);
        return ADDR_W'(idx * STRIDE + ofs);
    endfunction

    function automatic logic [DATA_W-1:0] bit0(input logic b);
        return {{(DATA_W-1){1'b0}}, b};
    endfunction

endpackage

// File: rtl/tmr_word.sv
module tmr_word
    import timer_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  word_cmd_t    cmd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] load_o
);

    logic [W-1:0] cnt_q, load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            load_q <= '0;
        end else begin
            if (cmd.ld_we) begin
                load_q <= wdata;
                cnt_q  <= wdata;
            end else if (cmd.reload) begin
                cnt_q  <= load_q;
            end else if (cmd.dec) begin
                cnt_q  <= cnt_q - W'(1);
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign load_o = load_q;

    // R9: a load write lands regardless of the other commands
    a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
        cmd.ld_we |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (q && !clr) |=> q);
    a_r6_cleared: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q);

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import timer_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [ADDR_W-1:0]             paddr,
    input  logic [DATA_W-1:0]             pwdata,
    input  logic [N_CNT-1:0][DATA_W-1:0]  cnt_i,
    input  logic [N_CNT-1:0][DATA_W-1:0]  load_i,
    input  logic [N_CNT-1:0]              raw_i,
    output tmr_ctrl_t [N_CNT-1:0]         ctrl_o,
    output logic                          mode64_o,
    output logic [N_CNT-1:0]              ld_we_o,
    output logic [N_CNT-1:0]              clr_o,
    output logic [DATA_W-1:0]             prdata
);

    logic wr;
    assign wr = psel && penable && pwrite;

    tmr_ctrl_t [N_CNT-1:0] ctrl_q;
    logic                  mode_q;

    for (genvar i = 0; i < N_CNT; i++) begin : g_dec
        assign ld_we_o[i] = wr && (paddr == reg_addr(i, OFS_LOAD));
        assign clr_o[i]   = wr && (paddr == reg_addr(i, OFS_CLR));

        always_ff @(posedge clk) begin
            if (rst)
                ctrl_q[i] <= '0;
            else if (wr && (paddr == reg_addr(i, OFS_CTRL)))
                ctrl_q[i] <= tmr_ctrl_t'(pwdata[2:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= 1'b0;
        else if (wr && (paddr == ADDR_W'(ADR_MODE)))
            mode_q <= pwdata[0];
    end

    always_comb begin
        prdata = '0;
        for (int i = 0; i < N_CNT; i++) begin
            if (paddr == reg_addr(i, OFS_LOAD)) prdata = load_i[i];
            if (paddr == reg_addr(i, OFS_LIVE)) prdata = cnt_i[i];
            if (paddr == reg_addr(i, OFS_CTRL)) prdata = {{(DATA_W-3){1'b0}}, ctrl_q[i]};
            if (paddr == reg_addr(i, OFS_RAW))  prdata = bit0(raw_i[i]);
            if (paddr == reg_addr(i, OFS_MSK))  prdata = bit0(raw_i[i] && ctrl_q[i].irq_en);
        end
        if (paddr == ADDR_W'(ADR_MODE)) prdata = bit0(mode_q);
    end

    assign ctrl_o   = ctrl_q;
    assign mode64_o = mode_q;

    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_we_o, clr_o}));

endmodule

// File: rtl/dual_dcount_timer.sv
module dual_dcount_timer
    import timer_pkg::*;
(
    input  logic              pclk,
    input  logic              presetn,
    input  logic              soft_rst_i,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq1_o,
    output logic              irq2_o
);

    localparam logic [2*DATA_W-1:0] ONE64 = {{(2*DATA_W-1){1'b0}}, 1'b1};

    logic rst;
    assign rst = !presetn || soft_rst_i;

    tmr_ctrl_t [N_CNT-1:0]         ctrl;
    logic                          mode64;
    logic [N_CNT-1:0]              ld_we, clr, evt, raw;
    logic [N_CNT-1:0][DATA_W-1:0]  cnt, load;
    word_cmd_t [N_CNT-1:0]         cmd;

    tmr_regfile u_regs (
        .clk      (pclk),
        .rst      (rst),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .cnt_i    (cnt),
        .load_i   (load),
        .raw_i    (raw),
        .ctrl_o   (ctrl),
        .mode64_o (mode64),
        .ld_we_o  (ld_we),
        .clr_o    (clr),
        .prdata   (prdata)
    );

    // Sequencing: independent words, or word 0 high / word 1 low cascade
    logic zero64, one64, run64;
    assign zero64 = (cnt[0] == '0) && (cnt[1] == '0);
    assign one64  = ({cnt[0], cnt[1]} == ONE64);
    assign run64  = ctrl[0].run;

    always_comb begin
        for (int i = 0; i < N_CNT; i++) begin
            cmd[i].ld_we  = ld_we[i];
            cmd[i].reload = 1'b0;
            cmd[i].dec    = 1'b0;
            evt[i]        = 1'b0;
        end
        if (mode64) begin
            cmd[1].dec    = run64 && !zero64;
            cmd[0].dec    = run64 && !zero64 && (cnt[1] == '0);
            cmd[0].reload = run64 && zero64 && ctrl[0].periodic;
            cmd[1].reload = cmd[0].reload;
            evt[0]        = run64 && one64;
        end else begin
            for (int i = 0; i < N_CNT; i++) begin
                cmd[i].dec    = ctrl[i].run && (cnt[i] != '0);
                cmd[i].reload = ctrl[i].run && (cnt[i] == '0) && ctrl[i].periodic;
                evt[i]        = ctrl[i].run && (cnt[i] == DATA_W'(1));
            end
        end
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        tmr_word #(.W(DATA_W)) u_word (
            .clk    (pclk),
            .rst    (rst),
            .cmd    (cmd[i]),
            .wdata  (pwdata),
            .cnt_o  (cnt[i]),
            .load_o (load[i])
        );

        tmr_flag u_flag (
            .clk (pclk),
            .rst (rst),
            .set (evt[i]),
            .clr (clr[i]),
            .q   (raw[i])
        );

        a_r3_step: assert property (@(posedge pclk) disable iff (rst)
            (!mode64 && ctrl[i].run && cnt[i] != '0 && !ld_we[i])
            |=> (cnt[i] == $past(cnt[i]) - DATA_W'(1)));

        a_r3_hold: assert property (@(posedge pclk) disable iff (rst)
            (!mode64 && !ctrl[i].run && !ld_we[i]) |=> $stable(cnt[i]));

        a_r4_oneshot_rest: assert property (@(posedge pclk) disable iff (rst)
            (!mode64 && ctrl[i].run && !ctrl[i].periodic && cnt[i] == '0 && !ld_we[i])
            |=> (cnt[i] == '0));

        a_r4_flag_on_zero: assert property (@(posedge pclk) disable iff (rst)
            (!mode64 && ctrl[i].run && cnt[i] == DATA_W'(1) && !ld_we[i])
            |=> (raw[i] && cnt[i] == '0));
    end

    assign irq1_o = raw[0] && ctrl[0].irq_en;
    assign irq2_o = raw[1] && ctrl[1].irq_en;

    a_r7_high_borrow: assert property (@(posedge pclk) disable iff (rst)
        (mode64 && !ld_we[0] && cnt[1] != '0) |=> $stable(cnt[0]));

    a_r7_no_low_event: assert property (@(posedge pclk) disable iff (rst)
        (mode64 && !raw[1]) |=> !raw[1]);

endmodule

// File: tb/dual_dcount_timer_tb.sv
module dual_dcount_timer_tb;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        soft_rst_i = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq1_o, irq2_o;

    always #4 pclk = ~pclk;

    dual_dcount_timer u_dut (
        .pclk(pclk), .presetn(presetn), .soft_rst_i(soft_rst_i),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq1_o(irq1_o), .irq2_o(irq2_o)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit cmp_on = 0;

    // ---------------- behavioural reference ----------------
    logic [31:0] m_cnt [2];
    logic [31:0] m_ld  [2];
    logic [2:0]  m_ctl [2];
    logic        m_ris [2];
    logic        m_mode;

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_ld[i] = 0; m_ctl[i] = 0; m_ris[i] = 0;
        end
        m_mode = 0;
    end

    always @(posedge pclk) begin
        logic [31:0] nc [2];
        logic        ev [2];
        logic        clr [2];
        logic [63:0] v;
        if (!presetn || soft_rst_i) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_ld[i] = 0; m_ctl[i] = 0; m_ris[i] = 0;
            end
            m_mode = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                nc[i] = m_cnt[i]; ev[i] = 0; clr[i] = 0;
            end
            if (m_mode) begin
                v = {m_cnt[0], m_cnt[1]};
                ev[0] = m_ctl[0][0] && (v == 64'd1);
                if (m_ctl[0][0] && v != 0) v = v - 1;
                else if (m_ctl[0][0] && m_ctl[0][2]) v = {m_ld[0], m_ld[1]};
                nc[0] = v[63:32]; nc[1] = v[31:0];
            end else begin
                for (int i = 0; i < 2; i++) begin
                    if (m_ctl[i][0]) begin
                        ev[i] = (m_cnt[i] == 1);
                        if (m_cnt[i] != 0) nc[i] = m_cnt[i] - 1;
                        else if (m_ctl[i][2]) nc[i] = m_ld[i];
                    end
                end
            end
            if (psel && penable && pwrite) begin
                case (paddr)
                    8'h00: begin m_ld[0] = pwdata; nc[0] = pwdata; end
                    8'h18: begin m_ld[1] = pwdata; nc[1] = pwdata; end
                    8'h08: m_ctl[0] = pwdata[2:0];
                    8'h20: m_ctl[1] = pwdata[2:0];
                    8'h0C: clr[0] = 1;
                    8'h24: clr[1] = 1;
                    8'h30: m_mode = pwdata[0];
                    default: ;
                endcase
            end
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = nc[i];
                if (ev[i]) m_ris[i] = 1;
                else if (clr[i]) m_ris[i] = 0;
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_ld[0];
            8'h04: return m_cnt[0];
            8'h08: return {29'd0, m_ctl[0]};
            8'h10: return {31'd0, m_ris[0]};
            8'h14: return {31'd0, m_ris[0] & m_ctl[0][1]};
            8'h18: return m_ld[1];
            8'h1C: return m_cnt[1];
            8'h20: return {29'd0, m_ctl[1]};
            8'h28: return {31'd0, m_ris[1]};
            8'h2C: return {31'd0, m_ris[1] & m_ctl[1][1]};
            8'h30: return {31'd0, m_mode};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every-clock comparison against the reference
    always @(negedge pclk) begin
        #1;
        if (cmp_on && !done) begin
            check("R5 irq1", {31'd0, irq1_o}, {31'd0, m_ris[0] & m_ctl[0][1]});
            check("R5 irq2", {31'd0, irq2_o}, {31'd0, m_ris[1] & m_ctl[1][1]});
            check("R2 prdata", prdata, m_read(paddr));
        end
    end

    // ---------------- APB tasks ----------------
    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        #2 d = prdata;
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge pclk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge pclk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    logic [31:0] r, r2;

    initial begin
        idle(4);
        cmp_on = 1;
        presetn = 1;                       // soft reset still held
        apb_wr(8'h00, 32'h55);
        apb_wr(8'h08, 32'h3);
        apb_rd(8'h04, r); check("R1 value during soft reset", r, 0);
        apb_rd(8'h08, r); check("R1 ctrl during soft reset", r, 0);
        check("R1 irq1 low", {31'd0, irq1_o}, 0);
        soft_rst_i = 0;
        apb_rd(8'h00, r); check("R1 load after release", r, 0);

        // R2 / R9: load sets live count; live register is read-only
        apb_wr(8'h00, 32'd20);
        apb_rd(8'h04, r); check("R2 live after load", r, 32'd20);
        apb_wr(8'h04, 32'd99);
        apb_rd(8'h04, r); check("R2 write to live ignored", r, 32'd20);

        // R8 ctrl readback, one-shot run with irq masked
        apb_wr(8'h08, 32'hFFFF_FFF9);
        apb_rd(8'h08, r); check("R8 ctrl readback", r, 32'd1);
        idle(30);
        apb_rd(8'h04, r); check("R4 one-shot rests at zero", r, 0);
        apb_rd(8'h10, r); check("R4 raw flag set", r, 1);
        apb_rd(8'h14, r); check("R5 masked status when disabled", r, 0);
        check("R5 irq1 masked", {31'd0, irq1_o}, 0);
        apb_wr(8'h08, 32'h3);
        check("R5 irq1 enabled", {31'd0, irq1_o}, 1);
        apb_wr(8'h0C, 32'h0);
        apb_rd(8'h10, r); check("R6 raw cleared", r, 0);
        check("R6 irq1 dropped", {31'd0, irq1_o}, 0);

        // R9/R3: load while counting, then two decrements before sampling
        apb_wr(8'h00, 32'd9);
        apb_rd(8'h04, r); check("R9 load mid-run then R3 steps", r, 32'd7);
        idle(12);

        // counter 2 periodic with clears landing on every phase
        apb_wr(8'h18, 32'd3);
        apb_wr(8'h20, 32'h7);
        for (int k = 0; k < 16; k++) apb_wr(8'h24, 32'd1);
        idle(9);
        apb_rd(8'h28, r); check("R4 periodic raises again", r, 1);
        apb_wr(8'h20, 32'h0);
        apb_rd(8'h1C, r); idle(5);
        apb_rd(8'h1C, r2); check("R3 stopped counter holds", r2, r);

        // 64-bit mode, zero high word
        apb_wr(8'h08, 32'h0);
        apb_wr(8'h0C, 32'h0);
        apb_wr(8'h24, 32'h0);
        apb_wr(8'h30, 32'h1);
        apb_rd(8'h30, r); check("R7 mode readback", r, 1);
        apb_wr(8'h00, 32'd0);
        apb_wr(8'h18, 32'd5);
        apb_wr(8'h20, 32'h3);              // ctrl2 has no effect here
        apb_wr(8'h08, 32'h3);
        idle(10);
        check("R7 irq1 on 64-bit zero", {31'd0, irq1_o}, 1);
        apb_rd(8'h28, r); check("R7 no low-word event", r, 0);

        // 64-bit borrow
        apb_wr(8'h08, 32'h0);
        apb_wr(8'h00, 32'd1);
        apb_wr(8'h18, 32'd2);
        apb_wr(8'h08, 32'h1);
        idle(10);
        apb_rd(8'h04, r); check("R7 high word borrowed once", r, 0);
        apb_rd(8'h1C, r); check("R7 low word wrapped", {8'd0, r[31:8]}, 32'h00FF_FFFF);

        // R8 unmapped / clear reads
        apb_rd(8'h34, r); check("R8 unmapped 0x34", r, 0);
        apb_rd(8'hFC, r); check("R8 unmapped 0xFC", r, 0);
        apb_rd(8'h0C, r); check("R8 clear reg reads zero", r, 0);

        // R1 soft reset mid-run
        soft_rst_i = 1;
        idle(2);
        soft_rst_i = 0;
        apb_rd(8'h1C, r); check("R1 soft reset clears count", r, 0);
        apb_rd(8'h30, r); check("R1 soft reset clears mode", r, 0);
        check("R1 irq1 low after soft reset", {31'd0, irq1_o}, 0);

        idle(3);
        finish_run();
    end

endmodule